// File: doc/BRIEF.md
# Clock-Stretch-Aware I2C Byte Master

This block is a single-master I2C engine that works one command at a time. It can issue a START, write one byte and capture the acknowledge, read one byte and answer with ACK or NACK, or issue a STOP. It drives both bus lines as open-drain: an output-enable pulls the line low, and a separate input reads back the real line level. Both inputs pass through a two-flop synchronizer before the control logic uses them.

Bit timing comes from a programmable quarter-bit divider. Each time the master releases SCL, it waits until the synchronized SCL is actually high before it starts the high half of the bit. The quarter counter restarts at that point, so a slave that holds SCL low lengthens the bit but never shortens the high phase. The wait is bounded. If SCL stays low for `cfg_timeout` consecutive clocks while the master has released it, the command is abandoned. Both lines are released, a sticky flag is raised, and no STOP is sent.

Commands enter on a valid/ready channel. A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the engine is idle and has no result waiting. Each accepted command produces exactly one result on the response channel. The result is held, unchanged, until `rsp_ready` is seen high, and no new command is accepted before then. SDA is sampled at the end of the first high quarter and changes only while SCL is low.

Top module: `i2c_stretch_master`

## Requirements
- R1: After reset both line enables are off, `cmd_ready` is 1, and `rsp_valid`, `busy` and `timeout_flag` are 0.
- R2: Op code 0 (START) makes SDA fall while SCL is high and leaves SCL held low. Op code 3 (STOP) drives SCL low, then makes SDA rise while SCL is high. START works both from an idle bus and as a repeated START with SCL held low.
- R3: Op code 1 (WRITE) shifts `cmd_wdata` onto SDA, most significant bit first. SDA changes only while SCL is low, so no START or STOP appears inside the byte. `rsp_nack` returns the level sampled on the ninth bit, where 0 means the slave acknowledged.
- R4: Op code 2 (READ) samples eight bits, most significant first, into `rsp_rdata`. On the ninth bit the master pulls SDA low when `cmd_nack` is 0 and leaves it released when `cmd_nack` is 1.
- R5: Every SCL high phase lasts at least 2×`cfg_quarter` clocks (values below 2 count as 2), measured on the bus. This holds even when a slave stretches the low phase, whether before the first bit or before the acknowledge bit.
- R6: If released SCL is seen low for `cfg_timeout` consecutive clocks (0 counts as 1), the command ends with `rsp_fail` set. Both enables are then off, `timeout_flag` is set, and no STOP is produced. A stretch shorter than the limit does not fail.
- R7: `timeout_flag` stays set until a START command is accepted, and accepting a START clears it.
- R8: The response is held stable while `rsp_valid` is 1 and `rsp_ready` is 0. `cmd_ready` is 0 from acceptance until the response is taken.
- R9: Each byte command produces exactly nine SCL rising edges on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_quarter | input | DIV_W | Clocks per quarter bit (minimum 2) |
| cfg_timeout | input | TO_W | Stretch limit in clocks |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_op | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | input | 8 | Byte to write |
| cmd_nack | input | 1 | READ: 1 answers NACK, 0 answers ACK |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken this cycle if valid |
| rsp_rdata | output | 8 | Byte seen on the bus (READ/WRITE) |
| rsp_nack | output | 1 | Ninth-bit level |
| rsp_fail | output | 1 | Command aborted by timeout |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| timeout_flag | output | 1 | Sticky timeout indication |
| busy | output | 1 | Command in progress or result pending |

## Verification
Two things can happen in the same cycle: the stretch timeout reaches its limit, and the slave's release of SCL becomes visible. When both occur together, the observed high level wins and the bit continues. The bench provokes the race by holding SCL for lengths both well inside and far beyond the limit, and at random bit positions including just before the acknowledge clock. Each outcome is judged at the ports. A run that completes must have full-length high phases and correct data. An abort must release both lines, raise the flag, and create no STOP once the slave lets go.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RSP,
    ST_S_LOW,
    ST_S_WAIT,
    ST_S_HIGH,
    ST_S_HOLD,
    ST_B_L1,
    ST_B_L2,
    ST_B_WAIT,
    ST_B_H1,
    ST_B_H2,
    ST_P_L1,
    ST_P_L2,
    ST_P_WAIT,
    ST_P_HIGH,
    ST_P_DONE
  } state_e;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/i2cm_qtimer.sv
module i2cm_qtimer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] cfg,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last = (cfg < DIV_W'(2)) ? DIV_W'(1) : cfg - DIV_W'(1);
  assign tick = run && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear || !run)  cnt_q <= '0;
    else if (tick)           cnt_q <= '0;
    else                     cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/i2cm_stretch_to.sv
module i2cm_stretch_to #(
  parameter int TO_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            waiting,
  input  logic            scl_high,
  input  logic [TO_W-1:0] cfg_timeout,
  output logic            expired
);
  logic [TO_W-1:0] cnt_q;
  logic [TO_W-1:0] last;

  assign last    = (cfg_timeout == '0) ? '0 : cfg_timeout - TO_W'(1);
  assign expired = waiting && !scl_high && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!waiting || scl_high)  cnt_q <= '0;
    else if (cnt_q != '1)           cnt_q <= cnt_q + TO_W'(1);
  end
endmodule

// File: rtl/i2c_stretch_master.sv
module i2c_stretch_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int TO_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_quarter,
  input  logic [TO_W-1:0]  cfg_timeout,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_wdata,
  input  logic             cmd_nack,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_rdata,
  output logic             rsp_nack,
  output logic             rsp_fail,
  input  logic             scl_i,
  output logic             scl_oe,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             timeout_flag,
  output logic             busy
);
  localparam int NBITS = 9;
  localparam int BW    = $clog2(NBITS + 1);
  localparam logic [BW-1:0] ACK_BIT = BW'(NBITS - 1);

  logic [1:0] line_s;
  logic       scl_s, sda_s;

  i2cm_sync #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  state_e        state_q, state_d;
  logic          scl_q, scl_d, sda_q, sda_d;
  logic [7:0]    sh_q, sh_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          ack_q, ack_d, fail_q, fail_d, flag_q, flag_d;
  logic          rd_q, rd_d, nk_q, nk_d;
  logic          run_c, wait_c, tick, expired, abort_c;
  op_e           op;

  assign op = op_e'(cmd_op);

  i2cm_qtimer #(.DIV_W(DIV_W)) u_qt (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_c),
    .clear(state_d != state_q),
    .cfg  (cfg_quarter),
    .tick (tick)
  );

  i2cm_stretch_to #(.TO_W(TO_W)) u_to (
    .clk        (clk),
    .rst_n      (rst_n),
    .waiting    (wait_c),
    .scl_high   (scl_s),
    .cfg_timeout(cfg_timeout),
    .expired    (expired)
  );

  always_comb begin
    state_d = state_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    ack_d   = ack_q;
    fail_d  = fail_q;
    flag_d  = flag_q;
    rd_d    = rd_q;
    nk_d    = nk_q;
    run_c   = 1'b0;
    wait_c  = 1'b0;
    abort_c = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          ack_d  = 1'b0;
          fail_d = 1'b0;
          bit_d  = '0;
          case (op)
            OP_START: begin
              flag_d  = 1'b0;
              sda_d   = 1'b0;
              state_d = scl_q ? ST_S_LOW : ST_S_WAIT;
            end
            OP_WRITE: begin
              sh_d    = cmd_wdata;
              rd_d    = 1'b0;
              state_d = ST_B_L1;
            end
            OP_READ: begin
              rd_d    = 1'b1;
              nk_d    = cmd_nack;
              state_d = ST_B_L1;
            end
            default: state_d = ST_P_L1;
          endcase
        end
      end
      ST_RSP: if (rsp_ready) state_d = ST_IDLE;
      // START: optional low quarter (repeated start), release, high quarter, SDA low
      ST_S_LOW: begin
        run_c = 1'b1;
        if (tick) begin
          scl_d   = 1'b0;
          state_d = ST_S_WAIT;
        end
      end
      ST_S_WAIT: begin
        wait_c = 1'b1;
        if (scl_s)        state_d = ST_S_HIGH;
        else if (expired) abort_c = 1'b1;
      end
      ST_S_HIGH: begin
        run_c = 1'b1;
        if (tick) begin
          sda_d   = 1'b1;
          state_d = ST_S_HOLD;
        end
      end
      ST_S_HOLD: begin
        run_c = 1'b1;
        if (tick) begin
          scl_d   = 1'b1;
          state_d = ST_RSP;
        end
      end
      // one data or acknowledge bit
      ST_B_L1: begin
        scl_d = 1'b1;
        run_c = 1'b1;
        if (tick) begin
          if (bit_q == ACK_BIT) sda_d = rd_q ? !nk_q : 1'b0;
          else                  sda_d = rd_q ? 1'b0 : !sh_q[7];
          state_d = ST_B_L2;
        end
      end
      ST_B_L2: begin
        run_c = 1'b1;
        if (tick) begin
          scl_d   = 1'b0;
          state_d = ST_B_WAIT;
        end
      end
      ST_B_WAIT: begin
        wait_c = 1'b1;
        if (scl_s)        state_d = ST_B_H1;
        else if (expired) abort_c = 1'b1;
      end
      ST_B_H1: begin
        run_c = 1'b1;
        if (tick) begin
          if (bit_q == ACK_BIT) ack_d = sda_s;
          else                  sh_d  = {sh_q[6:0], sda_s};
          state_d = ST_B_H2;
        end
      end
      ST_B_H2: begin
        run_c = 1'b1;
        if (tick) begin
          scl_d = 1'b1;
          if (bit_q == ACK_BIT) begin
            state_d = ST_RSP;
          end else begin
            bit_d   = bit_q + BW'(1);
            state_d = ST_B_L1;
          end
        end
      end
      // STOP: SCL low, SDA low, release SCL, wait, release SDA
      ST_P_L1: begin
        scl_d = 1'b1;
        run_c = 1'b1;
        if (tick) begin
          sda_d   = 1'b1;
          state_d = ST_P_L2;
        end
      end
      ST_P_L2: begin
        run_c = 1'b1;
        if (tick) begin
          scl_d   = 1'b0;
          state_d = ST_P_WAIT;
        end
      end
      ST_P_WAIT: begin
        wait_c = 1'b1;
        if (scl_s)        state_d = ST_P_HIGH;
        else if (expired) abort_c = 1'b1;
      end
      ST_P_HIGH: begin
        run_c = 1'b1;
        if (tick) begin
          sda_d   = 1'b0;
          state_d = ST_P_DONE;
        end
      end
      ST_P_DONE: begin
        run_c = 1'b1;
        if (tick) state_d = ST_RSP;
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_c) begin
      scl_d   = 1'b0;
      sda_d   = 1'b0;
      fail_d  = 1'b1;
      flag_d  = 1'b1;
      state_d = ST_RSP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      sh_q    <= '0;
      bit_q   <= '0;
      ack_q   <= 1'b0;
      fail_q  <= 1'b0;
      flag_q  <= 1'b0;
      rd_q    <= 1'b0;
      nk_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      ack_q   <= ack_d;
      fail_q  <= fail_d;
      flag_q  <= flag_d;
      rd_q    <= rd_d;
      nk_q    <= nk_d;
    end
  end

  assign cmd_ready    = (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign rsp_valid    = (state_q == ST_RSP);
  assign rsp_rdata    = sh_q;
  assign rsp_nack     = ack_q;
  assign rsp_fail     = fail_q;
  assign scl_oe       = scl_q;
  assign sda_oe       = sda_q;
  assign timeout_flag = flag_q;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata,
  input logic       rsp_nack,
  input logic       rsp_fail,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       timeout_flag,
  input logic       busy
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_nack) && $stable(rsp_fail)); // R8
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy); // R8
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fail |-> !scl_oe && !sda_oe); // R6
  AST_FAIL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fail |-> timeout_flag); // R6
  AST_FLAG_FROM_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> rsp_valid && rsp_fail); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag && !(cmd_valid && cmd_ready && cmd_op == 2'd0) |=> timeout_flag); // R7
endmodule

bind i2c_stretch_master i2cm_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .rsp_nack    (rsp_nack),
  .rsp_fail    (rsp_fail),
  .scl_oe      (scl_oe),
  .sda_oe      (sda_oe),
  .timeout_flag(timeout_flag),
  .busy        (busy)
);

// File: tb/i2c_stretch_master_tb.sv
module i2c_stretch_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_quarter = 16'd3;
  logic [19:0] cfg_timeout = 20'd400;
  logic        cmd_valid = 1'b0, cmd_nack = 1'b0, rsp_ready = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        cmd_ready, rsp_valid, rsp_nack, rsp_fail, scl_oe, sda_oe, timeout_flag, busy;
  logic [7:0]  rsp_rdata;
  logic        scl_bus, sda_bus;

  // bench slave configuration (written by tasks only)
  logic        slv_rst = 1'b0, slv_read = 1'b0, slv_ack = 1'b1;
  logic [7:0]  slv_tx = 8'h00;
  int          stretch_at = 99, stretch_len = 0, cur_q = 3;

  // bench slave state (written by the slave process only)
  logic        scl_prev = 1'b1, sda_low = 1'b0, mack = 1'b0;
  logic [7:0]  cap = 8'h00;
  int          rises = 15, hold_cnt = 0;

  // monitor state
  logic        m_scl = 1'b1, m_sda = 1'b1;
  int          starts = 0, stops = 0, hi_len = 0, mon_checks = 0, mon_fails = 0;

  int checks = 0, fails = 0, wd_fail = 0;
  logic [7:0] r_data;
  logic       r_nack, r_fail;

  assign scl_bus = !(scl_oe || hold_cnt > 0);
  assign sda_bus = !(sda_oe || sda_low);

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_stretch_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_quarter(cfg_quarter), .cfg_timeout(cfg_timeout),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cmd_nack(cmd_nack), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_nack(rsp_nack), .rsp_fail(rsp_fail), .scl_i(scl_bus), .scl_oe(scl_oe),
    .sda_i(sda_bus), .sda_oe(sda_oe), .timeout_flag(timeout_flag), .busy(busy)
  );

  // slave: shifts in on rising SCL, drives on falling SCL, stretches on request
  always @(posedge clk) begin
    scl_prev <= scl_bus;
    if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
    if (slv_rst) begin
      rises   <= 0;
      cap     <= 8'h00;
      sda_low <= slv_read ? !slv_tx[7] : 1'b0;
      if (stretch_at == 0 && stretch_len > 0) hold_cnt <= stretch_len;
    end else if (scl_bus && !scl_prev) begin
      if (rises < 8 && !slv_read) cap <= {cap[6:0], sda_bus};
      if (rises == 8 && slv_read) mack <= sda_bus;
      rises <= rises + 1;
    end else if (!scl_bus && scl_prev) begin
      if (slv_read) sda_low <= (rises < 8) ? !slv_tx[7 - rises] : 1'b0;
      else          sda_low <= (rises == 8) ? slv_ack : 1'b0;
      if (rises == stretch_at && stretch_len > 0) hold_cnt <= stretch_len;
    end
  end

  // monitor: START/STOP detection and high-phase length (R5)
  always @(posedge clk) begin
    m_scl <= scl_bus;
    m_sda <= sda_bus;
    if (rst_n) begin
      if (m_scl && scl_bus && m_sda && !sda_bus) starts <= starts + 1;
      if (m_scl && scl_bus && !m_sda && sda_bus) stops <= stops + 1;
      if (scl_bus) hi_len <= hi_len + 1;
      else begin
        if (m_scl) begin
          mon_checks <= mon_checks + 1;
          if (hi_len < 2 * cur_q) begin
            mon_fails <= mon_fails + 1;
            $display("FAIL R5 high phase actual=%0d expected>=%0d", hi_len, 2 * cur_q);
          end
        end
        hi_len <= 0;
      end
    end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             checks + mon_checks + wd_fail, fails + mon_fails + wd_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_nack_write(input logic ack_en);
    return !ack_en;
  endfunction

  task automatic slave_setup(input logic rd, input logic [7:0] tx, input logic ack,
                             input int at, input int len);
    @(negedge clk);
    slv_read = rd; slv_tx = tx; slv_ack = ack; stretch_at = at; stretch_len = len;
    slv_rst = 1'b1;
    @(negedge clk);
    slv_rst = 1'b0;
  endtask

  // issue one command and collect its result (R8 handshake checked here)
  task automatic run_cmd(input logic [1:0] op, input logic [7:0] wd, input logic nk);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_nack = nk;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 ready drops after accept", cmd_ready, 1'b0);
    while (!rsp_valid) @(negedge clk);
    r_data = rsp_rdata; r_nack = rsp_nack; r_fail = rsp_fail;
    repeat (2) @(negedge clk);
    chk("R8 response held", {rsp_valid, rsp_rdata, rsp_nack, rsp_fail},
        {1'b1, r_data, r_nack, r_fail});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d, input logic ack, input int at, input int len);
    int s0, p0;
    slave_setup(1'b0, 8'h00, ack, at, len);
    s0 = starts; p0 = stops;
    run_cmd(2'd1, d, 1'b0);
    chk("R3 slave captured byte", cap, d);
    chk("R3 ack level", r_nack, exp_nack_write(ack));
    chk("R3 no start/stop inside byte", {starts, stops}, {s0, p0});
    chk("R9 nine clocks", rises, 9);
    chk("R5 stretched write not failed", r_fail, 1'b0);
  endtask

  task automatic do_read(input logic [7:0] d, input logic nk, input int at, input int len);
    slave_setup(1'b1, d, 1'b0, at, len);
    run_cmd(2'd2, 8'h00, nk);
    chk("R4 read data", r_data, d);
    chk("R4 master ninth bit", mack, nk);
    chk("R9 nine clocks", rises, 9);
    chk("R5 stretched read not failed", r_fail, 1'b0);
  endtask

  task automatic do_start();
    int s0;
    s0 = starts;
    run_cmd(2'd0, 8'h00, 1'b0);
    chk("R2 start seen", starts, s0 + 1);
    chk("R2 start holds SCL low", scl_oe, 1'b1);
  endtask

  task automatic do_stop();
    int p0;
    p0 = stops;
    run_cmd(2'd3, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2 stop seen", stops, p0 + 1);
  endtask

  initial begin
    int p0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset enables", {scl_oe, sda_oe}, 2'b00);
    chk("R1 reset handshake", {cmd_ready, rsp_valid, busy, timeout_flag}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed traffic
    do_start();
    do_write(8'hA5, 1'b1, 99, 0);
    do_write(8'h5A, 1'b0, 99, 0);
    do_read(8'h3C, 1'b0, 0, 80);          // stretch right after a read command
    do_write(8'hC3, 1'b1, 8, 60);         // stretch before the acknowledge clock
    do_read(8'h96, 1'b1, 8, 60);
    do_start();                            // repeated START with SCL held
    do_stop();

    // timeout abort
    cfg_timeout = 20'd200;
    do_start();
    slave_setup(1'b0, 8'h00, 1'b1, 3, 2000);
    p0 = stops;
    run_cmd(2'd1, 8'hF0, 1'b0);
    chk("R6 fail reported", r_fail, 1'b1);
    chk("R6 flag set", timeout_flag, 1'b1);
    chk("R6 lines released", {scl_oe, sda_oe}, 2'b00);
    repeat (2100) @(negedge clk);
    chk("R6 no stop issued", stops, p0);
    run_cmd(2'd3, 8'h00, 1'b0);
    chk("R7 flag survives stop", timeout_flag, 1'b1);
    do_start();
    chk("R7 flag cleared by start", timeout_flag, 1'b0);
    do_write(8'h11, 1'b1, 2, 100);        // shorter than limit: R6 no failure
    do_stop();
    cfg_timeout = 20'd400;

    // constrained random traffic
    for (int t = 0; t < 25; t++) begin
      cur_q = 2 + int'($urandom_range(3));
      cfg_quarter = 16'(cur_q);
      do_start();
      for (int b = 0; b < 1 + int'($urandom_range(2)); b++) begin
        int at, len;
        at  = ($urandom_range(1) == 0) ? 99 : int'($urandom_range(8));
        len = 10 + int'($urandom_range(140));
        if ($urandom_range(1) == 0)
          do_write(8'($urandom), 1'($urandom), at, len);
        else
          do_read(8'($urandom), 1'($urandom), at, len);
      end
      do_stop();
    end
    report();
  end
endmodule